// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block drives the two phase-select lines of an external dual-slope integrating converter. It steps the converter through four phases in a loop: auto-zero, integrate, de-integrate and integrator-zero. It also measures how long the de-integrate phase runs before the comparator reports that the integrator has crossed zero. All sequencing runs from a slow timebase. That timebase is a clock enable taken from the oscillator clock divided by four, so the whole block stays in one clock domain.

The lengths of the auto-zero and integrate phases both come from a programmable load byte. It is the upper part of a phase length whose lower bits are fixed at all ones. De-integrate has a timeout of twice the integrate length. Integrator-zero has a fixed short length. An active-low enable input works as an override. While it is high, the sequencer is held in auto-zero, and any conversion in progress is dropped without a result. A new load byte is picked up only when an auto-zero phase starts. The system around the block writes the load byte and reads the count when the result strobe pulses.

Top module: `dslope_seq`

## Requirements
- R1: The phase lines {ctl_a, ctl_b} carry auto-zero = 01, integrate = 10, de-integrate = 11 and integrator-zero = 00. The phases follow each other only in the order auto-zero, integrate, de-integrate, integrator-zero, then auto-zero again. The one exception is the jump to auto-zero caused by the enable override.
- R2: Every phase change and every result strobe happens on a timebase tick. A tick comes every DIV oscillator cycles (DIV = 4), so every phase lasts a whole multiple of DIV oscillator cycles.
- R3: Auto-zero and integrate each last N ticks, with N = {load, LOW_W ones} + 1. With the default 8-bit load and 8-bit fixed part, load 0xFF gives 65536 and load 0x7F gives 32768.
- R4: In de-integrate, cmp_pos is sampled once per tick. The phase ends at the first tick that samples it low. dint_count then equals the number of ticks spent in de-integrate, counting that tick. dint_valid is high for exactly one oscillator cycle, in the same cycle in which the lines first show integrator-zero.
- R5: If cmp_pos stays high, de-integrate ends after 2*N ticks with dint_count = 2*N and a strobe.
- R6: Integrator-zero lasts IZ_LEN = 4 ticks.
- R7: When conv_en_n is sampled high at a tick, the next phase is auto-zero. The sequencer stays there while conv_en_n stays high, and no strobe is produced for the dropped conversion. After conv_en_n returns low, auto-zero lasts a full N ticks.
- R8: az_n is low exactly while the lines show auto-zero, whether the sequencer got there by normal sequencing or by the override.
- R9: A change of load_val during integrate or de-integrate has no effect on the current conversion, including its timeout. The load is captured at the first tick of each auto-zero phase, and again at every tick while the override holds auto-zero.
- R10: While rst_n is low, the block shows auto-zero (lines 01, az_n low), dint_valid low and dint_count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en_n | input | 1 | Active-low conversion enable; high forces and holds auto-zero |
| cmp_pos | input | 1 | Comparator, high while the integrator output is positive |
| load_val | input | LOAD_W | Upper part of the auto-zero/integrate length |
| ctl_a | output | 1 | Phase select line A (upper bit of the phase code) |
| ctl_b | output | 1 | Phase select line B (lower bit of the phase code) |
| az_n | output | 1 | Low while in auto-zero |
| dint_count | output | LOAD_W+LOW_W+2 | De-integrate tick count of the last completed conversion |
| dint_valid | output | 1 | One-cycle strobe when dint_count is updated |

## Verification
Every load value of a reduced configuration (3-bit load, 2-bit fixed part) is run through conversions in which the comparator drops on the first tick, on tick N, on tick 2N-1, or never. These four cases separate an off-by-one in the count, an early timeout and a missing timeout. The measured lengths of auto-zero, integrate and integrator-zero show whether the divide and the length formula are right. A load change during integrate must leave the timeout at the old length. Override pulses during integrate and during de-integrate test that the jump to auto-zero happens, that it holds, that no strobe appears, and that a full-length auto-zero follows release.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  // Phase code as driven on the two select lines {a, b}
  typedef enum logic [1:0] {
    PH_IZ   = 2'b00,
    PH_AZ   = 2'b01,
    PH_INT  = 2'b10,
    PH_DINT = 2'b11
  } phase_t;

  // Normal successor of each phase in the conversion loop
  function automatic phase_t succ(input phase_t p);
    case (p)
      PH_AZ:   return PH_INT;
      PH_INT:  return PH_DINT;
      PH_DINT: return PH_IZ;
      default: return PH_AZ;
    endcase
  endfunction

endpackage

// File: rtl/dslope_clkdiv.sv
module dslope_clkdiv #(
  parameter int DIV = 4
) (
  input  logic osc_clk,
  input  logic rst_n,
  output logic sys_tick
);

  generate
    if (DIV <= 1) begin : g_nodiv
      logic run_q;
      always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
      end
      assign sys_tick = run_q;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end

      assign sys_tick = (div_q == LAST);

      // R2: ticks are isolated pulses, never on two cycles in a row
      p_tick_gap_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        sys_tick |=> !sys_tick);
    end
  endgenerate

endmodule

// File: rtl/dslope_timebase.sv
module dslope_timebase
  import dslope_pkg::*;
#(
  parameter int LOAD_W = 8,
  parameter int LOW_W  = 8,
  parameter int IZ_LEN = 4,
  parameter int CNT_W  = LOAD_W + LOW_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick,
  input  logic [LOAD_W-1:0] load_val,
  input  phase_t            phase,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  elapsed,
  output logic              len_done,
  output logic              tmo_done,
  output logic              iz_done
);

  // Last tick index of an auto-zero / integrate phase: {load, ones}
  function automatic logic [CNT_W-1:0] last_len_tick(input logic [LOAD_W-1:0] ld);
    return CNT_W'({ld, {LOW_W{1'b1}}});
  endfunction

  // Last tick index of de-integrate before timeout: 2*len - 1
  function automatic logic [CNT_W-1:0] last_tmo_tick(input logic [LOAD_W-1:0] ld);
    return CNT_W'({ld, {LOW_W{1'b1}}, 1'b1});
  endfunction

  logic [LOAD_W-1:0] cur_load;
  logic              load_grab;

  assign load_grab = sys_tick && (phase == PH_AZ) && (elapsed == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_load <= '1;
    else if (load_grab) cur_load <= load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        elapsed <= '0;
    else if (sys_tick) elapsed <= cnt_clr ? '0 : elapsed + 1'b1;
  end

  assign len_done = (elapsed == last_len_tick(cur_load));
  assign tmo_done = (elapsed == last_tmo_tick(cur_load));
  assign iz_done  = (elapsed == CNT_W'(IZ_LEN - 1));

  // R9: committed load only moves inside auto-zero
  p_load_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_AZ) |-> $stable(cur_load));

  // R5: de-integrate never counts past its timeout
  p_dint_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DINT) |-> (elapsed <= last_tmo_tick(cur_load)));

  // R6: integrator-zero never counts past its fixed length
  p_iz_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IZ) |-> (elapsed < CNT_W'(IZ_LEN)));

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sys_tick,
  input  logic   conv_en_n,
  input  logic   cmp_pos,
  input  logic   len_done,
  input  logic   tmo_done,
  input  logic   iz_done,
  output phase_t phase,
  output logic   cnt_clr,
  output logic   dint_stop
);

  phase_t nxt;
  logic   stop_c;

  always_comb begin
    nxt    = phase;
    stop_c = 1'b0;
    if (conv_en_n) begin
      nxt = PH_AZ;
    end else begin
      case (phase)
        PH_AZ:   if (len_done) nxt = PH_INT;
        PH_INT:  if (len_done) nxt = PH_DINT;
        PH_DINT: if (!cmp_pos || tmo_done) begin
                   nxt    = PH_IZ;
                   stop_c = 1'b1;
                 end
        default: if (iz_done) nxt = PH_AZ;
      endcase
    end
  end

  assign cnt_clr   = conv_en_n || (nxt != phase);
  assign dint_stop = sys_tick && stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= PH_AZ;
    else if (sys_tick) phase <= nxt;
  end

  // R1: only the normal successor or a forced auto-zero may follow
  p_seq_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> ((phase == succ($past(phase))) || (phase == PH_AZ)));

  // R7: enable high at a tick lands in auto-zero
  p_override_az_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && conv_en_n) |=> (phase == PH_AZ));

  // R7: a dropped conversion produces no result event
  p_no_stop_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dint_stop |-> !conv_en_n);

endmodule

// File: rtl/dslope_capture.sv
module dslope_capture #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dint_stop,
  input  logic [CNT_W-1:0] elapsed,
  output logic [CNT_W-1:0] result,
  output logic             result_stb
);

  // Ticks spent in de-integrate, counting the terminating one
  function automatic logic [CNT_W-1:0] ticks_spent(input logic [CNT_W-1:0] idx);
    return idx + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_stb <= 1'b0;
    end else begin
      result_stb <= dint_stop;
      if (dint_stop) result <= ticks_spent(elapsed);
    end
  end

  // R4: strobe lasts one cycle
  p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_stb |=> !result_stb);

  // R4: result only changes together with the strobe
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !result_stb |-> $stable(result));

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int LOAD_W = 8,
  parameter int LOW_W  = 8,
  parameter int DIV    = 4,
  parameter int IZ_LEN = 4,
  localparam int CNT_W = LOAD_W + LOW_W + 2
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              conv_en_n,
  input  logic              cmp_pos,
  input  logic [LOAD_W-1:0] load_val,
  output logic              ctl_a,
  output logic              ctl_b,
  output logic              az_n,
  output logic [CNT_W-1:0]  dint_count,
  output logic              dint_valid
);

  logic             sys_tick;
  phase_t           phase;
  logic             cnt_clr;
  logic             dint_stop;
  logic [CNT_W-1:0] elapsed;
  logic             len_done;
  logic             tmo_done;
  logic             iz_done;

  dslope_clkdiv #(.DIV(DIV)) u_div (
    .osc_clk  (osc_clk),
    .rst_n    (rst_n),
    .sys_tick (sys_tick)
  );

  dslope_timebase #(
    .LOAD_W (LOAD_W),
    .LOW_W  (LOW_W),
    .IZ_LEN (IZ_LEN),
    .CNT_W  (CNT_W)
  ) u_tb (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .sys_tick (sys_tick),
    .load_val (load_val),
    .phase    (phase),
    .cnt_clr  (cnt_clr),
    .elapsed  (elapsed),
    .len_done (len_done),
    .tmo_done (tmo_done),
    .iz_done  (iz_done)
  );

  dslope_ctrl u_ctrl (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .sys_tick  (sys_tick),
    .conv_en_n (conv_en_n),
    .cmp_pos   (cmp_pos),
    .len_done  (len_done),
    .tmo_done  (tmo_done),
    .iz_done   (iz_done),
    .phase     (phase),
    .cnt_clr   (cnt_clr),
    .dint_stop (dint_stop)
  );

  dslope_capture #(.CNT_W(CNT_W)) u_cap (
    .clk        (osc_clk),
    .rst_n      (rst_n),
    .dint_stop  (dint_stop),
    .elapsed    (elapsed),
    .result     (dint_count),
    .result_stb (dint_valid)
  );

  assign ctl_a = phase[1];
  assign ctl_b = phase[0];
  assign az_n  = (phase != PH_AZ);

  // R8: auto-zero is entered only from integrator-zero or by the override
  p_az_entry_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $fell(az_n) |-> ($past(conv_en_n) || ($past(phase) == PH_IZ)));

  // R2: phase changes only on a tick
  p_tick_aligned_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> $past(sys_tick));

endmodule

// File: tb/dslope_seq_bench.sv
module dslope_seq_bench;
  localparam int LW  = 3;
  localparam int SW  = 2;
  localparam int DV  = 4;
  localparam int IZL = 4;
  localparam int CW  = LW + SW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_n = 1'b0;
  logic          cmp = 1'b1;
  logic [LW-1:0] load = '0;
  logic          a, b, az_n, dv;
  logic [CW-1:0] cnt;

  always #4 clk = ~clk;

  dslope_seq #(.LOAD_W(LW), .LOW_W(SW), .DIV(DV), .IZ_LEN(IZL)) u_dslope_seq (
    .osc_clk(clk), .rst_n(rst_n), .conv_en_n(en_n), .cmp_pos(cmp),
    .load_val(load), .ctl_a(a), .ctl_b(b), .az_n(az_n),
    .dint_count(cnt), .dint_valid(dv)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int run = 0;
  int last_dur = 0;
  bit done = 0;
  logic [1:0] ab_prev = 2'b01;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int plen(input int l);
    return (l + 1) * (1 << SW);
  endfunction

  function automatic logic [1:0] after(input logic [1:0] p);
    case (p)
      2'b01: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  // Phase-run monitor, R1 order, R8 flag, strobe placement, watchdog
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      run = 0;
      ab_prev = 2'b01;
    end else begin
      if ({a, b} != ab_prev) begin
        chk(({a, b} == after(ab_prev)) || ({a, b} == 2'b01), "R1", "phase step",
            int'({a, b}), int'(after(ab_prev)));
        last_dur = run;
        run = 1;
        ab_prev = {a, b};
      end else begin
        run++;
      end
      if (az_n != ({a, b} != 2'b01))
        chk(1'b0, "R8", "az_n vs phase", int'(az_n), int'({a, b} != 2'b01));
      if (dv) chk({a, b} == 2'b00, "R4", "phase at strobe", int'({a, b}), 0);
    end
    if (cyc > 180000 && !done) begin
      done = 1;
      chk(1'b0, "WD", "watchdog", cyc, 180000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ab(input logic [1:0] code, input string req);
    int n = 0;
    do begin
      step();
      n++;
    end while ({a, b} != code && n < 5000);
    if ({a, b} != code) chk(1'b0, req, "phase never reached", int'({a, b}), int'(code));
  endtask

  // One conversion; k = 0 means the comparator never drops
  task automatic conv(input int l, input int k, input bit first,
                      input bit chg, input int nl);
    int len = plen(l);
    int kexp = (k > 0) ? k : 2 * len;
    int n = 0;
    load = LW'(l);
    wait_ab(2'b01, "R1");
    if (!first) chk(last_dur == IZL * DV, "R6", "integrator-zero length", last_dur, IZL * DV);
    wait_ab(2'b10, "R1");
    if (!first) chk(last_dur == len * DV, "R2 R3", "auto-zero length", last_dur, len * DV);
    cmp = 1'b1;
    if (chg) load = LW'(nl);
    wait_ab(2'b11, "R1");
    chk(last_dur == len * DV, "R3", "integrate length", last_dur, len * DV);
    while (!dv && n < 20000) begin
      if (k > 0 && n == 4 * k - 2) cmp = 1'b0;
      step();
      n++;
    end
    chk(n == kexp * DV, (k > 0) ? "R4" : "R5", "de-integrate length", n, kexp * DV);
    chk(int'(cnt) == kexp, (k > 0) ? "R4" : "R5", "count", int'(cnt), kexp);
    if (chg) chk(int'(cnt) == 2 * len, "R9", "timeout with old load", int'(cnt), 2 * len);
    step();
    chk(!dv, "R4", "strobe width", int'(dv), 0);
    cmp = 1'b1;
  endtask

  initial begin
    int bad;
    int n;
    int len;
    load = 3'd2;
    repeat (3) step();
    chk({a, b} == 2'b01 && !az_n, "R10", "reset phase", int'({a, b}), 1);
    chk(!dv && cnt == '0, "R10", "reset result", int'(cnt), 0);
    rst_n = 1'b1;

    conv(2, 3, 1'b1, 1'b0, 0);
    for (int l = 0; l < (1 << LW); l++) begin
      conv(l, 1, 1'b0, 1'b0, 0);
      conv(l, plen(l), 1'b0, 1'b0, 0);
      conv(l, 2 * plen(l) - 1, 1'b0, 1'b0, 0);
      conv(l, 0, 1'b0, 1'b0, 0);
    end

    // R9: load raised during integrate keeps the old timeout
    conv(1, 0, 1'b0, 1'b1, 7);
    conv(7, 5, 1'b0, 1'b0, 0);

    // R7: override during integrate, hold, release
    load = 3'd3;
    len = plen(3);
    wait_ab(2'b10, "R7");
    repeat (6) step();
    en_n = 1'b1;
    n = 0;
    while ({a, b} != 2'b01 && n < 10) begin step(); n++; end
    chk(n <= DV, "R7", "override entry delay", n, DV);
    chk(!az_n, "R8", "az_n under override", int'(az_n), 0);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if ({a, b} != 2'b01 || dv || az_n) bad++;
    end
    chk(bad == 0, "R7", "held in auto-zero", bad, 0);
    en_n = 1'b0;
    n = 0;
    while ({a, b} != 2'b10 && n < 1000) begin step(); n++; end
    chk(n >= 4 * len - 3 && n <= 4 * len, "R7", "auto-zero after release", n, 4 * len);

    // R7: override during de-integrate drops the result
    cmp = 1'b1;
    wait_ab(2'b11, "R7");
    repeat (5) step();
    en_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (dv) bad++;
    end
    chk(bad == 0, "R7", "no strobe on dropped conversion", bad, 0);
    chk({a, b} == 2'b01, "R7", "forced auto-zero", int'({a, b}), 1);
    en_n = 1'b0;
    conv(3, 2, 1'b1, 1'b0, 0);
    conv(0, 1, 1'b0, 1'b0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule